// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading two levels of a page table from memory. The virtual address is cut into a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit byte offset, so pages are 4 KB. The walk begins at a root frame held in a base register that only kernel mode may change. It reads the directory entry, then the leaf entry, checks the permission bits of both, and then either reports a fault or returns the translation. When the leaf entry's accessed or dirty flag has to change, the walker writes the leaf entry back to memory. It writes nothing back when neither flag changes.

A requester presents one access at a time on a valid/ready pair, with flags for a write and for a user-mode access. The walker talks to memory through one word-wide port with at most one request outstanding. Each request is a single-cycle pulse, and the answer is `mem_resp_valid` in a later cycle. The result comes out as a single-cycle `done_valid` pulse that carries a fault code and the physical address.

The controller is a five-state machine:
- `ST_IDLE` waits for a request and moves to `ST_READ_L1` when one is accepted.
- `ST_READ_L1` issues the directory read. When the answer arrives it goes to `ST_DONE` if the entry is not present, and to `ST_READ_L2` otherwise.
- `ST_READ_L2` issues the leaf read. When the answer arrives it goes to `ST_DONE` on any fault or when no flag changes, and to `ST_UPDATE_PTE` when the accessed or dirty flag must be set.
- `ST_UPDATE_PTE` writes the leaf entry back and moves to `ST_DONE` on the acknowledge.
- `ST_DONE` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `ptw_walker`

## Requirements
- R1: The first memory read of a walk is at address root_frame*4096 + va[31:22]*4. The root frame is the base register value captured when the request is accepted.
- R2: When the directory entry is present, the second read is at address dir[31:12]*4096 + va[21:12]*4.
- R3: A walk without a fault returns done_paddr = {leaf[31:12], va[11:0]} and done_fault = 0.
- R4: A clear present bit (bit 0) in an entry at either level ends the walk with done_fault = 1, which is the page fault. A directory that is not present causes exactly one memory read, and done_paddr is 0 on any fault.
- R5: A user access (req_user = 1) faults with done_fault = 2, the protection fault, unless the user bit (bit 2) is set in both entries.
- R6: A write access (req_write = 1) faults with done_fault = 2 unless the writable bit (bit 1) is set in both entries. This holds in kernel mode as well.
- R7: After a successful walk, the leaf entry in memory has the accessed bit (bit 5) set. On a write it also has the dirty bit (bit 6) set. Every other bit of the entry keeps its value. The walker issues exactly one write when a flag changes and no write otherwise.
- R8: base_wr_en loads base_wr_frame into the root frame only while kernel_mode = 1. A load attempted in user mode leaves the root frame unchanged.
- R9: A page fault takes priority over a protection fault. A walk that faults writes nothing to memory.
- R10: req_ready is high only in the idle state. At most one memory request is outstanding. done_valid lasts exactly one cycle. After reset the walker is idle, with no memory request and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| kernel_mode | input | 1 | High when the current privilege is kernel |
| base_wr_en | input | 1 | Request to load the root frame register |
| base_wr_frame | input | 20 | New root frame number |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| mem_req_valid | output | 1 | One-cycle memory request pulse |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_resp_valid | input | 1 | Read data or write acknowledge |
| mem_resp_rdata | input | 32 | Read data |
| done_valid | output | 1 | One-cycle result pulse |
| done_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| done_paddr | output | 32 | Physical address, 0 on fault |

## Verification
A state register that goes wrong shows up at the memory port within the next one or two cycles. Examples are a second read after a missing directory, a write-back after a fault, or two requests back to back. A corrupted latched entry field shows up as a wrong second read address, a wrong fault code, or a wrong physical address on the very next done pulse. A bad update value changes the leaf word in memory, and that word is inspected after every walk. The sweep covers all combinations of the present, writable and user bits at both levels, each kind of access, and every starting state of the accessed and dirty flags.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned PTW_XLEN  = 32;
    localparam int unsigned PTW_IDX_W = 10;
    localparam int unsigned PTW_OFF_W = 12;

    // entry flag positions
    localparam int unsigned PTE_PRESENT  = 0;
    localparam int unsigned PTE_WRITABLE = 1;
    localparam int unsigned PTE_USER     = 2;
    localparam int unsigned PTE_WTHRU    = 3;
    localparam int unsigned PTE_NOCACHE  = 4;
    localparam int unsigned PTE_ACCESSED = 5;
    localparam int unsigned PTE_DIRTY    = 6;

    typedef enum logic [1:0] {
        FAULT_NONE = 2'd0,
        FAULT_PAGE = 2'd1,
        FAULT_PROT = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_L1,
        ST_READ_L2,
        ST_UPDATE_PTE,
        ST_DONE
    } walk_state_e;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
    parameter int unsigned FRAME_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kernel_mode,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_frame,
    output logic [FRAME_W-1:0] base_frame
);

    logic [FRAME_W-1:0] frame_q;

    // privilege gate: user-mode loads are dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (wr_en && kernel_mode) begin
            frame_q <= wr_frame;
        end
    end

    assign base_frame = frame_q;

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12
) (
    input  logic [XLEN-OFF_W-1:0] frame,
    input  logic [IDX_W-1:0]      index,
    output logic [XLEN-1:0]       entry_addr
);

    localparam int unsigned ENTRY_SHIFT = 2;

    always_comb begin
        entry_addr = (XLEN'(frame) << OFF_W) + (XLEN'(index) << ENTRY_SHIFT);
    end

endmodule

// File: rtl/ptw_perm_eval.sv
module ptw_perm_eval
    import ptw_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            dir_writable,
    input  logic            dir_user,
    input  logic [XLEN-1:0] leaf_pte,
    input  logic            acc_write,
    input  logic            acc_user,
    output fault_e          leaf_fault,
    output logic [XLEN-1:0] upd_pte,
    output logic            upd_needed
);

    logic eff_writable;
    logic eff_user;
    logic perm_bad;

    always_comb begin
        eff_writable = dir_writable & leaf_pte[PTE_WRITABLE];
        eff_user     = dir_user & leaf_pte[PTE_USER];
        perm_bad     = (acc_user && !eff_user) || (acc_write && !eff_writable);

        if (!leaf_pte[PTE_PRESENT]) begin
            leaf_fault = FAULT_PAGE;
        end else if (perm_bad) begin
            leaf_fault = FAULT_PROT;
        end else begin
            leaf_fault = FAULT_NONE;
        end

        upd_pte = leaf_pte;
        upd_pte[PTE_ACCESSED] = 1'b1;
        if (acc_write) begin
            upd_pte[PTE_DIRTY] = 1'b1;
        end
        upd_needed = (upd_pte != leaf_pte);
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int unsigned XLEN  = PTW_XLEN,
    parameter int unsigned IDX_W = PTW_IDX_W,
    parameter int unsigned OFF_W = PTW_OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  kernel_mode,
    input  logic                  base_wr_en,
    input  logic [XLEN-OFF_W-1:0] base_wr_frame,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [XLEN-1:0]       req_vaddr,
    input  logic                  req_write,
    input  logic                  req_user,
    output logic                  mem_req_valid,
    output logic                  mem_req_write,
    output logic [XLEN-1:0]       mem_req_addr,
    output logic [XLEN-1:0]       mem_req_wdata,
    input  logic                  mem_resp_valid,
    input  logic [XLEN-1:0]       mem_resp_rdata,
    output logic                  done_valid,
    output logic [1:0]            done_fault,
    output logic [XLEN-1:0]       done_paddr
);

    localparam int unsigned FRAME_W = XLEN - OFF_W;
    localparam int unsigned L2_LSB  = OFF_W;
    localparam int unsigned L1_LSB  = OFF_W + IDX_W;

    walk_state_e state_q, state_d;

    logic               pending_q;
    logic [XLEN-1:0]    vaddr_q;
    logic               write_q;
    logic               user_q;
    logic [FRAME_W-1:0] root_frame_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic               dir_w_q;
    logic               dir_u_q;
    logic [XLEN-1:0]    leaf_pte_q;
    fault_e             fault_q;
    logic [XLEN-1:0]    paddr_q;

    logic [FRAME_W-1:0] base_frame_q;
    logic [XLEN-1:0]    l1_addr;
    logic [XLEN-1:0]    l2_addr;
    fault_e             leaf_fault;
    logic [XLEN-1:0]    upd_pte;
    logic               upd_needed;
    logic               resp_hit;

    ptw_base_reg #(
        .FRAME_W (FRAME_W)
    ) i_base (
        .clk         (clk),
        .rst_n       (rst_n),
        .kernel_mode (kernel_mode),
        .wr_en       (base_wr_en),
        .wr_frame    (base_wr_frame),
        .base_frame  (base_frame_q)
    );

    ptw_addr_gen #(
        .XLEN  (XLEN),
        .IDX_W (IDX_W),
        .OFF_W (OFF_W)
    ) i_l1_addr (
        .frame      (root_frame_q),
        .index      (vaddr_q[L1_LSB +: IDX_W]),
        .entry_addr (l1_addr)
    );

    ptw_addr_gen #(
        .XLEN  (XLEN),
        .IDX_W (IDX_W),
        .OFF_W (OFF_W)
    ) i_l2_addr (
        .frame      (dir_frame_q),
        .index      (vaddr_q[L2_LSB +: IDX_W]),
        .entry_addr (l2_addr)
    );

    ptw_perm_eval #(
        .XLEN (XLEN)
    ) i_perm (
        .dir_writable (dir_w_q),
        .dir_user     (dir_u_q),
        .leaf_pte     (mem_resp_rdata),
        .acc_write    (write_q),
        .acc_user     (user_q),
        .leaf_fault   (leaf_fault),
        .upd_pte      (upd_pte),
        .upd_needed   (upd_needed)
    );

    assign resp_hit = pending_q && mem_resp_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_READ_L1;
                end
            end
            ST_READ_L1: begin
                if (resp_hit) begin
                    state_d = mem_resp_rdata[PTE_PRESENT] ? ST_READ_L2 : ST_DONE;
                end
            end
            ST_READ_L2: begin
                if (resp_hit) begin
                    if (leaf_fault != FAULT_NONE || !upd_needed) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_UPDATE_PTE;
                    end
                end
            end
            ST_UPDATE_PTE: begin
                if (resp_hit) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        done_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_READ_L1: begin
                mem_req_valid = !pending_q;
                mem_req_addr  = l1_addr;
            end
            ST_READ_L2: begin
                mem_req_valid = !pending_q;
                mem_req_addr  = l2_addr;
            end
            ST_UPDATE_PTE: begin
                mem_req_valid = !pending_q;
                mem_req_write = 1'b1;
                mem_req_addr  = l2_addr;
                mem_req_wdata = leaf_pte_q;
            end
            ST_DONE: begin
                done_valid = 1'b1;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    assign done_fault = fault_q;
    assign done_paddr = paddr_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q    <= 1'b0;
            vaddr_q      <= '0;
            write_q      <= 1'b0;
            user_q       <= 1'b0;
            root_frame_q <= '0;
            dir_frame_q  <= '0;
            dir_w_q      <= 1'b0;
            dir_u_q      <= 1'b0;
            leaf_pte_q   <= '0;
            fault_q      <= FAULT_NONE;
            paddr_q      <= '0;
        end else begin
            if (mem_req_valid) begin
                pending_q <= 1'b1;
            end else if (mem_resp_valid) begin
                pending_q <= 1'b0;
            end

            if (state_q == ST_IDLE && req_valid) begin
                vaddr_q      <= req_vaddr;
                write_q      <= req_write;
                user_q       <= req_user;
                root_frame_q <= base_frame_q;
                fault_q      <= FAULT_NONE;
                paddr_q      <= '0;
            end

            if (state_q == ST_READ_L1 && resp_hit) begin
                dir_frame_q <= mem_resp_rdata[XLEN-1:OFF_W];
                dir_w_q     <= mem_resp_rdata[PTE_WRITABLE];
                dir_u_q     <= mem_resp_rdata[PTE_USER];
                if (!mem_resp_rdata[PTE_PRESENT]) begin
                    fault_q <= FAULT_PAGE;
                end
            end

            if (state_q == ST_READ_L2 && resp_hit) begin
                fault_q    <= leaf_fault;
                leaf_pte_q <= upd_pte;
                if (leaf_fault == FAULT_NONE) begin
                    paddr_q <= {mem_resp_rdata[XLEN-1:OFF_W], vaddr_q[OFF_W-1:0]};
                end
            end
        end
    end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned FRAME_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               kernel_mode,
    input logic               base_wr_en,
    input logic [FRAME_W-1:0] base_frame,
    input logic               req_ready,
    input logic               mem_req_valid,
    input logic               mem_req_write,
    input logic [XLEN-1:0]    mem_req_wdata,
    input logic               done_valid,
    input logic [1:0]         done_fault
);

    AST_BASE_USER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr_en && !kernel_mode) |=> $stable(base_frame)); // R8

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !done_valid)); // R10

    AST_WRITEBACK_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[5]); // R7

    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_fault != 2'd3)); // R4

endmodule

bind ptw_walker ptw_walker_chk #(
    .XLEN    (XLEN),
    .FRAME_W (FRAME_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .kernel_mode   (kernel_mode),
    .base_wr_en    (base_wr_en),
    .base_frame    (base_frame_q),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_wdata (mem_req_wdata),
    .done_valid    (done_valid),
    .done_fault    (done_fault)
);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kernel_mode = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [19:0] base_wr_frame = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_rdata = '0;
    logic        done_valid;
    logic [1:0]  done_fault;
    logic [31:0] done_paddr;

    // 125 MHz
    always #4 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk            (clk),
        .rst_n          (rst_n),
        .kernel_mode    (kernel_mode),
        .base_wr_en     (base_wr_en),
        .base_wr_frame  (base_wr_frame),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .req_write      (req_write),
        .req_user       (req_user),
        .mem_req_valid  (mem_req_valid),
        .mem_req_write  (mem_req_write),
        .mem_req_addr   (mem_req_addr),
        .mem_req_wdata  (mem_req_wdata),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_rdata (mem_resp_rdata),
        .done_valid     (done_valid),
        .done_fault     (done_fault),
        .done_paddr     (done_paddr)
    );

    // memory model: 64 KB, one-cycle answer
    logic [31:0] mem [0:16383];
    logic        poke_en = 1'b0;
    logic [31:0] poke_addr = '0;
    logic [31:0] poke_data = '0;
    logic        clr_stats = 1'b0;
    int          rd_count = 0;
    int          wr_count = 0;
    logic [31:0] rd_addr0 = '0;
    logic [31:0] rd_addr1 = '0;
    logic [31:0] wr_addr0 = '0;

    always @(posedge clk) begin
        mem_resp_valid <= 1'b0;
        if (poke_en) begin
            mem[poke_addr[15:2]] <= poke_data;
        end
        if (clr_stats) begin
            rd_count <= 0;
            wr_count <= 0;
        end else if (mem_req_valid) begin
            mem_resp_valid <= 1'b1;
            if (mem_req_write) begin
                mem[mem_req_addr[15:2]] <= mem_req_wdata;
                if (wr_count == 0) wr_addr0 <= mem_req_addr;
                wr_count <= wr_count + 1;
            end else begin
                mem_resp_rdata <= mem[mem_req_addr[15:2]];
                if (rd_count == 0) rd_addr0 <= mem_req_addr;
                if (rd_count == 1) rd_addr1 <= mem_req_addr;
                rd_count <= rd_count + 1;
            end
        end
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic set_base(input logic km, input logic [19:0] f);
        @(negedge clk);
        kernel_mode = km; base_wr_en = 1'b1; base_wr_frame = f;
        @(negedge clk);
        base_wr_en = 1'b0; kernel_mode = 1'b0;
    endtask

    function automatic logic [31:0] mk_pte(input logic [19:0] pfn, input logic p,
                                           input logic w, input logic u,
                                           input logic a, input logic d);
        return {pfn, 3'b101, 2'b00, d, a, 2'b00, u, w, p};
    endfunction

    logic busy_ready_seen;
    logic done_stuck;

    task automatic walk(input logic [31:0] va, input logic wr, input logic usr,
                        output logic timed_out);
        int n;
        @(negedge clk);
        clr_stats = 1'b1;
        @(negedge clk);
        clr_stats = 1'b0;
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        busy_ready_seen = 1'b0;
        n = 0;
        while (!done_valid && n < 100) begin
            if (req_ready) busy_ready_seen = 1'b1;
            @(negedge clk);
            n++;
        end
        timed_out = (n >= 100);
    endtask

    initial begin
        logic to;
        int base_f;
        #20000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic to;
        repeat (3) @(negedge clk);
        // reset state (R10)
        chk("R10 reset req_ready", {31'd0, req_ready}, 32'd1);
        chk("R10 reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        chk("R10 reset done_valid", {31'd0, done_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: kernel load, then ignored user load
        set_base(1'b1, 20'd1);
        set_base(1'b0, 20'd7);
        poke(32'h0000_1000, mk_pte(20'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
        poke(32'h0000_2000, mk_pte(20'h12345, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
        walk(32'h0000_0ABC, 1'b0, 1'b0, to);
        chk("R8 user base load ignored", rd_addr0, 32'h0000_1000);
        chk("R3 basic paddr", done_paddr, 32'h1234_5ABC);

        // R8: kernel load to frame 3 takes effect
        set_base(1'b1, 20'd3);
        poke(32'h0000_3000 + 32'd8, mk_pte(20'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
        walk(32'h0080_0123, 1'b0, 1'b0, to);
        chk("R8 kernel base load", rd_addr0, 32'h0000_3008);
        chk("R1 root capture", rd_count, 32'd2);
        set_base(1'b1, 20'd1);

        // exhaustive sweep over flag and access combinations
        for (int k = 0; k < 1024; k++) begin
            logic p1, w1, u1, p2, w2, u2, wr, usr, a0, d0;
            logic [9:0]  i1, i2;
            logic [11:0] off;
            logic [19:0] lpfn;
            logic [31:0] va, leaf0, leaf_exp, l1a, l2a;
            logic [1:0]  exp_code;
            logic        wb;
            {d0, a0, usr, wr, u2, w2, p2, u1, w1, p1} = k[9:0];
            i1   = 10'(k * 37 + 1);
            i2   = 10'(k * 91 + 5);
            off  = 12'(k * 123);
            lpfn = 20'hA5000 + 20'(k);
            va   = {i1, i2, off};
            l1a  = 32'h0000_1000 + {20'd0, i1, 2'b00};
            l2a  = 32'h0000_2000 + {20'd0, i2, 2'b00};
            leaf0 = mk_pte(lpfn, p2, w2, u2, a0, d0);
            poke(l1a, mk_pte(20'd2, p1, w1, u1, 1'b0, 1'b0));
            poke(l2a, leaf0);

            if (!p1 || !p2) exp_code = 2'd1;
            else if ((usr && !(u1 && u2)) || (wr && !(w1 && w2))) exp_code = 2'd2;
            else exp_code = 2'd0;
            leaf_exp = leaf0;
            if (exp_code == 2'd0) begin
                leaf_exp[5] = 1'b1;
                if (wr) leaf_exp[6] = 1'b1;
            end
            wb = (leaf_exp != leaf0);

            walk(va, wr, usr, to);
            if (to) begin
                n_checks++; n_fail++;
                $display("FAIL R10 walk timeout k=%0d actual=busy expected=done", k);
            end else begin
                if (!p1) begin
                    chk("R4 page fault at directory", {30'd0, done_fault}, 32'd1);
                end else if (!p2) begin
                    chk("R4 page fault at leaf", {30'd0, done_fault}, 32'd1);
                end else if (usr && !(u1 && u2)) begin
                    chk("R5 user permission", {30'd0, done_fault}, {30'd0, exp_code});
                end else begin
                    chk("R6 write permission", {30'd0, done_fault}, {30'd0, exp_code});
                end
                chk("R1 directory address", rd_addr0, l1a);
                chk("R4 read count", rd_count, p1 ? 32'd2 : 32'd1);
                if (p1) chk("R2 leaf address", rd_addr1, l2a);
                chk("R3 paddr", done_paddr, exp_code == 2'd0 ? {lpfn, off} : 32'd0);
                chk("R9 R7 writeback count", wr_count, wb ? 32'd1 : 32'd0);
                if (wb) chk("R7 writeback address", wr_addr0, l2a);
                chk("R7 leaf content", mem[l2a[15:2]], leaf_exp);
                chk("R10 ready low while busy", {31'd0, busy_ready_seen}, 32'd0);
                @(negedge clk);
                chk("R10 done one cycle", {31'd0, done_valid}, 32'd0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule